// File: doc/BRIEF.md
# Trap and Interrupt Priority Arbiter

This block chooses, on every clock, the one event a processor core should service next. Synchronous trap requests come in as a bit vector. Interrupt requests arrive from two places: an 8-bit programmed-interrupt field, and a single bus interrupt source that reports its level and its vector. The arbiter compares them against the current processor priority. It then registers one decision: a take strobe, the vector address to fetch, a one-hot mask that clears the serviced trap request, an acknowledge for the bus source, and a wake signal for a core that is idling until an interrupt arrives.

Traps always win over interrupts. Among traps, the cause with the highest index wins. Each trap index has a fixed vector from a parameter table, and the stack-overflow-fatal cause sits at the top index. Interrupts are scanned from level 7 downward, and only levels strictly above the current priority are considered. When a programmed interrupt and a bus interrupt share a level, the programmed one is taken. The vector fetch, the stack pushes and the status-word update are left to the core that consumes the decision.

Top module: `evarb_top`

## Requirements
- R1: If any trap request bit is set, a trap is dispatched: take is high, bus_ack is low and wake is low, whatever interrupts are pending.
- R2: Among pending traps the highest index wins, and vector carries that index's table entry. With default parameters, indices 0 to 7 map to 0x000C, 0x0010, 0x0014, 0x0018, 0x001C, 0x00A8, 0x0008 and 0x0004. Index 7 is the stack-overflow-fatal cause.
- R3: When a trap is dispatched, trap_clr is one-hot at the serviced index. trap_clr is zero for every other outcome.
- R4: An interrupt at level L is eligible only when L > cur_pri. Levels at or below cur_pri never produce take.
- R5: Bit i of pirq_req requests a programmed interrupt at level i. An accepted programmed interrupt gives vector 0x00A0 with bus_ack and wake low.
- R6: An eligible bus interrupt (bus_pend high, level bus_lvl) with no trap pending and no higher-or-equal programmed interrupt gives take, vector = bus_vec and bus_ack high.
- R7: Between interrupts, the higher level wins. At equal level, the programmed interrupt beats the bus interrupt.
- R8: wake is high exactly when a bus interrupt is accepted while wait_st is high. A programmed interrupt or a trap never raises wake.
- R9: When nothing qualifies, take, vector, trap_clr, bus_ack and wake are all zero. At most one event is reported per cycle.
- R10: Each decision appears on the outputs at the first rising clock edge after its inputs are applied.
- R11: While rst_n is low all outputs are zero. Release of rst_n is synchronised to clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 8 | Pending trap causes, one bit per table index |
| pirq_req | input | 8 | Programmed-interrupt requests, bit i = level i |
| cur_pri | input | 3 | Current processor priority |
| bus_pend | input | 1 | Bus interrupt pending |
| bus_lvl | input | 3 | Level of the pending bus interrupt |
| bus_vec | input | 16 | Vector supplied by the bus source |
| wait_st | input | 1 | Core is idling until an interrupt |
| take | output | 1 | An event is dispatched this cycle |
| vector | output | 16 | Vector address of the dispatched event |
| trap_clr | output | 8 | One-hot clear for the serviced trap request |
| bus_ack | output | 1 | Acknowledge to the bus interrupt source |
| wake | output | 1 | Return the core from its idle state |

## Verification
Every output is due exactly one rising edge after the inputs that produce it. The bench therefore drives a pattern on the falling edge and waits for a single rising edge. It samples shortly after that edge, before the next pattern is applied, so each check sees one stimulus only. A directed latency test also samples just before that edge and confirms the previous decision is still held. The reset check samples while rst_n is low, because reset clears the outputs without waiting for the clock.

// File: rtl/evarb_pkg.sv
package evarb_pkg;

  localparam int unsigned VEC_W    = 16;
  localparam int unsigned N_TRAP   = 8;
  localparam int unsigned N_LEVEL  = 8;
  localparam int unsigned LVL_W    = $clog2(N_LEVEL);
  localparam logic [VEC_W-1:0] PIRQ_VECTOR = 16'h00A0;

  // index 0 .. 7, highest index has highest precedence (7 = stack fatal)
  localparam logic [N_TRAP*VEC_W-1:0] TRAP_VEC_TABLE = {
    16'h0004, 16'h0008, 16'h00A8, 16'h001C,
    16'h0018, 16'h0014, 16'h0010, 16'h000C
  };

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_TRAP = 2'd1,
    EV_PIRQ = 2'd2,
    EV_BUS  = 2'd3
  } ev_kind_e;

endpackage

// File: rtl/evarb_rst_sync.sv
module evarb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/evarb_trap_pick.sv
module evarb_trap_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned VW    = 16,
  parameter logic [N*VW-1:0] VTAB = '0
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [N-1:0]  sel,
  output logic [VW-1:0] vec
);

  // later (higher) indices overwrite lower ones: highest index wins
  always_comb begin
    hit = 1'b0;
    sel = '0;
    vec = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (req[i]) begin
        hit = 1'b1;
        sel = '0;
        sel[i] = 1'b1;
        vec = VTAB[i*VW +: VW];
      end
    end
  end

endmodule

// File: rtl/evarb_irq_pick.sv
module evarb_irq_pick #(
  parameter int unsigned NL = 8,
  parameter int unsigned LW = 3
) (
  input  logic [NL-1:0] pirq,
  input  logic [LW-1:0] pri,
  input  logic          bus_pend,
  input  logic [LW-1:0] bus_lvl,
  output logic          pirq_hit,
  output logic          bus_hit
);

  logic [NL-1:0] lvl_ok;
  logic [NL-1:0] p_at;
  logic [NL-1:0] b_at;

  genvar g;
  generate
    for (g = 0; g < int'(NL); g++) begin : g_lvl
      assign lvl_ok[g] = (LW'(g) > pri);
      assign p_at[g]   = lvl_ok[g] & pirq[g];
      assign b_at[g]   = lvl_ok[g] & bus_pend & (bus_lvl == LW'(g)) & ~pirq[g];
    end
  endgenerate

  // scan upward, overwriting: the highest eligible level decides
  always_comb begin
    pirq_hit = 1'b0;
    bus_hit  = 1'b0;
    for (int l = 1; l < int'(NL); l++) begin
      if (p_at[l]) begin
        pirq_hit = 1'b1;
        bus_hit  = 1'b0;
      end else if (b_at[l]) begin
        pirq_hit = 1'b0;
        bus_hit  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/evarb_top.sv
module evarb_top
  import evarb_pkg::*;
#(
  parameter int unsigned NT = N_TRAP,
  parameter int unsigned NL = N_LEVEL,
  parameter int unsigned VW = VEC_W,
  parameter logic [NT*VW-1:0] VTAB = TRAP_VEC_TABLE,
  parameter logic [VW-1:0] PIRQ_VEC = PIRQ_VECTOR
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NT-1:0]  trap_req,
  input  logic [NL-1:0]  pirq_req,
  input  logic [$clog2(NL)-1:0] cur_pri,
  input  logic           bus_pend,
  input  logic [$clog2(NL)-1:0] bus_lvl,
  input  logic [VW-1:0]  bus_vec,
  input  logic           wait_st,
  output logic           take,
  output logic [VW-1:0]  vector,
  output logic [NT-1:0]  trap_clr,
  output logic           bus_ack,
  output logic           wake
);

  localparam int unsigned LW = $clog2(NL);

  logic          rst_s;
  logic          t_hit;
  logic [NT-1:0] t_sel;
  logic [VW-1:0] t_vec;
  logic          p_hit;
  logic          b_hit;

  ev_kind_e      kind_d, kind_q;
  logic [VW-1:0] vec_d, vec_q;
  logic [NT-1:0] clr_d, clr_q;
  logic          wake_d, wake_q;

  evarb_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s)
  );

  evarb_trap_pick #(.N(NT), .VW(VW), .VTAB(VTAB)) i_trap_pick (
    .req (trap_req),
    .hit (t_hit),
    .sel (t_sel),
    .vec (t_vec)
  );

  evarb_irq_pick #(.NL(NL), .LW(LW)) i_irq_pick (
    .pirq     (pirq_req),
    .pri      (cur_pri),
    .bus_pend (bus_pend),
    .bus_lvl  (bus_lvl),
    .pirq_hit (p_hit),
    .bus_hit  (b_hit)
  );

  // next-state
  always_comb begin
    kind_d = EV_NONE;
    vec_d  = '0;
    clr_d  = '0;
    wake_d = 1'b0;
    if (t_hit) begin
      kind_d = EV_TRAP;
      vec_d  = t_vec;
      clr_d  = t_sel;
    end else if (p_hit) begin
      kind_d = EV_PIRQ;
      vec_d  = PIRQ_VEC;
    end else if (b_hit) begin
      kind_d = EV_BUS;
      vec_d  = bus_vec;
      wake_d = wait_st;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      kind_q <= EV_NONE;
      vec_q  <= '0;
      clr_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      kind_q <= kind_d;
      vec_q  <= vec_d;
      clr_q  <= clr_d;
      wake_q <= wake_d;
    end
  end

  assign take     = (kind_q != EV_NONE);
  assign vector   = vec_q;
  assign trap_clr = clr_q;
  assign bus_ack  = (kind_q == EV_BUS);
  assign wake     = wake_q;

  // R1: any pending trap beats every interrupt
  a_r1_trap_wins: assert property (@(posedge clk) disable iff (!rst_s)
    (|trap_req) |=> (take && !bus_ack && !wake));

  // R3: clear mask is one-hot and names a request that was pending
  a_r3_clr_onehot: assert property (@(posedge clk) disable iff (!rst_s)
    (|trap_req) |=> ($countones(trap_clr) == 1 && (trap_clr & ~$past(trap_req)) == '0));

  // R4: an acknowledged bus interrupt was above the priority
  a_r4_level_above: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_pend && bus_lvl <= cur_pri && trap_req == '0 && pirq_req == '0) |=> !take);

  // R8: wake only accompanies a bus acknowledge
  a_r8_wake_bus: assert property (@(posedge clk) disable iff (!rst_s)
    wake |-> bus_ack);

  // R9: idle outputs are all zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_s)
    !take |-> (vector == '0 && trap_clr == '0 && !bus_ack && !wake));

  // R9: one event per cycle
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({|trap_clr, bus_ack}));

endmodule

// File: tb/test_evarb_top.sv
module test_evarb_top;

  logic        clk;
  logic        rst_n;
  logic [7:0]  trap_req;
  logic [7:0]  pirq_req;
  logic [2:0]  cur_pri;
  logic        bus_pend;
  logic [2:0]  bus_lvl;
  logic [15:0] bus_vec;
  logic        wait_st;
  logic        take;
  logic [15:0] vector;
  logic [7:0]  trap_clr;
  logic        bus_ack;
  logic        wake;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  typedef struct packed {
    logic [7:0]  trap;
    logic [7:0]  pirq;
    logic [2:0]  pri;
    logic        pend;
    logic [2:0]  lvl;
    logic [15:0] bvec;
    logic        wt;
    logic        e_take;
    logic [15:0] e_vec;
    logic [7:0]  e_clr;
    logic        e_ack;
    logic        e_wake;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    // R9 idle
    '{8'h00, 8'h00, 3'd0, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0},
    // R1 R2 R3 trap over everything, index 2 wins over 0
    '{8'h05, 8'hFF, 3'd0, 1'b1, 3'd7, 16'h0070, 1'b1, 1'b1, 16'h0014, 8'h04, 1'b0, 1'b0},
    // R2 stack-fatal index 7 highest
    '{8'h81, 8'h00, 3'd0, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b1, 16'h0004, 8'h80, 1'b0, 1'b0},
    // R2 index 5 alone
    '{8'h20, 8'h00, 3'd7, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b1, 16'h00A8, 8'h20, 1'b0, 1'b0},
    // R5 pirq level 4 above pri 3
    '{8'h00, 8'h10, 3'd3, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b1, 16'h00A0, 8'h00, 1'b0, 1'b0},
    // R4 pirq level 4 at pri 4 ignored
    '{8'h00, 8'h10, 3'd4, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0},
    // R6 R8 bus level 5, waiting -> wake
    '{8'h00, 8'h00, 3'd3, 1'b1, 3'd5, 16'h0060, 1'b1, 1'b1, 16'h0060, 8'h00, 1'b1, 1'b1},
    // R4 bus level 5 at pri 5 ignored
    '{8'h00, 8'h00, 3'd5, 1'b1, 3'd5, 16'h0060, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0},
    // R7 R8 same level: programmed wins, no wake
    '{8'h00, 8'h20, 3'd0, 1'b1, 3'd5, 16'h0060, 1'b1, 1'b1, 16'h00A0, 8'h00, 1'b0, 1'b0},
    // R7 R8 bus level 6 beats pirq level 3, not waiting
    '{8'h00, 8'h08, 3'd0, 1'b1, 3'd6, 16'h0070, 1'b0, 1'b1, 16'h0070, 8'h00, 1'b1, 1'b0},
    // R7 pirq level 6 beats bus level 2
    '{8'h00, 8'h40, 3'd0, 1'b1, 3'd2, 16'h0070, 1'b1, 1'b1, 16'h00A0, 8'h00, 1'b0, 1'b0},
    // R4 bus level 0 never eligible
    '{8'h00, 8'h01, 3'd0, 1'b1, 3'd0, 16'h0070, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0},
    // R5 level 7 above pri 6
    '{8'h00, 8'h81, 3'd6, 1'b0, 3'd7, 16'h0070, 1'b0, 1'b1, 16'h00A0, 8'h00, 1'b0, 1'b0},
    // R9 level given but nothing pending
    '{8'h00, 8'h00, 3'd0, 1'b0, 3'd7, 16'h0070, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b0, 1'b0}
  };

  evarb_top i_evarb_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .trap_req (trap_req),
    .pirq_req (pirq_req),
    .cur_pri  (cur_pri),
    .bus_pend (bus_pend),
    .bus_lvl  (bus_lvl),
    .bus_vec  (bus_vec),
    .wait_st  (wait_st),
    .take     (take),
    .vector   (vector),
    .trap_clr (trap_clr),
    .bus_ack  (bus_ack),
    .wake     (wake)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [26:0] act, input logic [26:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got take=%b vec=%h clr=%h ack=%b wake=%b, want take=%b vec=%h clr=%h ack=%b wake=%b",
               req, act[26], act[25:10], act[9:2], act[1], act[0],
               exp[26], exp[25:10], exp[9:2], exp[1], exp[0]);
    end
  endtask

  function automatic logic [26:0] outs();
    return {take, vector, trap_clr, bus_ack, wake};
  endfunction

  task automatic drive(input vec_t v);
    trap_req = v.trap;
    pirq_req = v.pirq;
    cur_pri  = v.pri;
    bus_pend = v.pend;
    bus_lvl  = v.lvl;
    bus_vec  = v.bvec;
    wait_st  = v.wt;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(TBL[1]);
    #23;
    // R11 reset state while inputs request a trap
    check("R11 reset", outs(), 27'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(TBL[0]);
    repeat (4) @(negedge clk);
    check("R11 after release idle", outs(), 27'd0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(TBL[k]);
      @(posedge clk);
      #2;
      check($sformatf("R1-table row %0d", k), outs(),
            {TBL[k].e_take, TBL[k].e_vec, TBL[k].e_clr, TBL[k].e_ack, TBL[k].e_wake});
    end

    // R10 latency: decision held until the next rising edge
    @(negedge clk);
    drive(TBL[6]);
    @(posedge clk);
    #2;
    @(negedge clk);
    drive(TBL[4]);
    #3;
    check("R10 before edge holds old", outs(), {1'b1, 16'h0060, 8'h00, 1'b1, 1'b1});
    @(posedge clk);
    #2;
    check("R10 after edge new", outs(), {1'b1, 16'h00A0, 8'h00, 1'b0, 1'b0});

    // R3 clear for index 0 alone
    @(negedge clk);
    drive('{8'h01, 8'h00, 3'd0, 1'b0, 3'd0, 16'h0, 1'b0, 1'b0, 16'h0, 8'h0, 1'b0, 1'b0});
    @(posedge clk);
    #2;
    check("R3 index0 clear", outs(), {1'b1, 16'h000C, 8'h01, 1'b0, 1'b0});

    // R11 mid-run reset clears at once
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R11 async clear", outs(), 27'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(TBL[0]);
    repeat (4) @(negedge clk);
    check("R9 idle after reset", outs(), 27'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule